// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block is a small per-core queue that sits between a core's load/store port and a shared memory. Stores are accepted in program order and held in the queue. The oldest entry is offered to memory each cycle, and it leaves the queue in the cycle that memory grants it. The result is a total-store-order memory model: a core's stores reach memory strictly in the order it issued them, but its own loads do not wait for them.

A load is answered in the same cycle. If one or more queued stores target the load address, the youngest of them supplies the data. If none does, the load reads memory directly and so may overtake older queued stores to other addresses. Because of this, two cores that each set their own flag and then read both flags can each see their own flag set and the other one clear. A fence input lets a core hold back later loads until its queue is empty. When the queue is full the block raises a stall and drops any store offered in that cycle.

Top module: `store_buffer`

## Requirements
- R1: After reset the queue is empty, `full_o` is low, `mem_wr_req_o` is low and `ld_ready_o` is high.
- R2: A store offered with `st_valid_i` high while `full_o` is low is queued at the next rising edge. From then on `mem_wr_req_o` is high and, if the queue was empty, `mem_wr_addr_o`/`mem_wr_data_o` show that store.
- R3: A load whose address matches a queued store returns that store's data in the same cycle, with `ld_hit_o` high. It does not wait for the store to reach memory.
- R4: When several queued stores match the load address, the data comes from the most recently queued one.
- R5: The queue holds DEPTH entries (4 by default). With DEPTH entries queued `full_o` is high, and a store offered in that cycle is discarded: it never reaches memory and is never forwarded.
- R6: The oldest entry is presented on the memory write port and held unchanged until `mem_gnt_i` is high. It then leaves the queue at that edge, so memory receives the stores in the order they were queued.
- R7: A load with no matching queued store drives `mem_rd_addr_o` = `ld_addr_i`, returns `mem_rd_data_i` with `ld_hit_o` low, and completes even while older stores to other addresses are still queued.
- R8: A one-cycle pulse on `fence_i` while the queue still holds entries after that edge drives `ld_ready_o` low from the next cycle on. It rises again in the first cycle the queue is empty. A fence on an empty queue leaves `ld_ready_o` high.
- R9: Two instances share one memory. Core 0 stores 1 to X, core 1 stores 1 to Y, and both stores are still queued. Core 0 then reads X as 1 and Y as 0, and core 1 reads Y as 1 and X as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store offered this cycle |
| st_addr_i | input | ADDR_W | Store address |
| st_data_i | input | DATA_W | Store data |
| full_o | output | 1 | Queue full; offered store is dropped |
| ld_valid_i | input | 1 | Load issued this cycle |
| ld_addr_i | input | ADDR_W | Load address |
| ld_ready_o | output | 1 | Loads allowed (low while a fence waits) |
| ld_hit_o | output | 1 | Load data came from the queue |
| ld_data_o | output | DATA_W | Load result |
| fence_i | input | 1 | Fence request pulse |
| mem_wr_req_o | output | 1 | Oldest entry requests a memory write |
| mem_wr_addr_o | output | ADDR_W | Write address of oldest entry |
| mem_wr_data_o | output | DATA_W | Write data of oldest entry |
| mem_gnt_i | input | 1 | Memory accepts the write this cycle |
| mem_rd_addr_o | output | ADDR_W | Memory read address for a load miss |
| mem_rd_data_i | input | DATA_W | Memory read data |

## Verification
The bound checker watches the local invariants on every cycle. These are: occupancy never exceeds DEPTH; a store offered while full leaves occupancy unchanged; an ungranted head stays put; occupancy stays constant with no store and no grant; a fence blocks loads while entries remain; and loads are only blocked while the queue holds data. The bench scenarios cover the behaviour that shows up only as values over a sequence of operations. That means youngest-match forwarding, a load bypassing queued stores, the order of writes reaching memory, the loss of a refused store, and the two-core flag outcome that sequential consistency would forbid.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_DEPTH  = 4;
  localparam int SB_ADDR_W = 8;
  localparam int SB_DATA_W = 16;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [ADDR_W-1:0]        push_addr_i,
  input  logic [DATA_W-1:0]        push_data_i,
  input  logic                     pop_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic [ADDR_W-1:0]        head_addr_o,
  output logic [DATA_W-1:0]        head_data_o,
  output logic [DEPTH*ADDR_W-1:0]  age_addr_o,
  output logic [DEPTH*DATA_W-1:0]  age_data_o,
  output logic [DEPTH-1:0]         age_vld_o
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  assign cnt_o       = cnt_q;
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];

  // slot k of the age view is the k-th oldest entry
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PTR_W-1:0] idx;
    assign idx = rd_ptr_q + PTR_W'(k);
    assign age_addr_o[k*ADDR_W +: ADDR_W] = addr_q[idx];
    assign age_data_o[k*DATA_W +: DATA_W] = data_q[idx];
    assign age_vld_o[k] = (CNT_W'(k) < cnt_q);
  end
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DEPTH*ADDR_W-1:0] age_addr_i,
  input  logic [DEPTH*DATA_W-1:0] age_data_i,
  input  logic [DEPTH-1:0]        age_vld_i,
  output logic                    hit_o,
  output logic [DATA_W-1:0]       data_o
);
  // ascending age scan: later (younger) matches override earlier ones
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (age_vld_i[k] && age_addr_i[k*ADDR_W +: ADDR_W] == addr_i) begin
        hit_o  = 1'b1;
        data_o = age_data_i[k*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH  = SB_DEPTH,
  parameter int ADDR_W = SB_ADDR_W,
  parameter int DATA_W = SB_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              full_o,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              ld_ready_o,
  output logic              ld_hit_o,
  output logic [DATA_W-1:0] ld_data_o,
  input  logic              fence_i,
  output logic              mem_wr_req_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_gnt_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [DATA_W-1:0] mem_rd_data_i
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]        occ, occ_nxt;
  logic                    push, pop, fence_pend_q;
  logic [DEPTH*ADDR_W-1:0] age_addr;
  logic [DEPTH*DATA_W-1:0] age_data;
  logic [DEPTH-1:0]        age_vld;
  logic                    fwd_hit;
  logic [DATA_W-1:0]       fwd_data;

  assign full_o       = (occ == CNT_W'(DEPTH));
  assign push         = st_valid_i && !full_o;
  assign mem_wr_req_o = (occ != '0);
  assign pop          = mem_wr_req_o && mem_gnt_i;
  assign occ_nxt      = occ + CNT_W'(push) - CNT_W'(pop);

  sb_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (st_addr_i),
    .push_data_i (st_data_i),
    .pop_i       (pop),
    .cnt_o       (occ),
    .head_addr_o (mem_wr_addr_o),
    .head_data_o (mem_wr_data_o),
    .age_addr_o  (age_addr),
    .age_data_o  (age_data),
    .age_vld_o   (age_vld)
  );

  sb_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fwd (
    .addr_i     (ld_addr_i),
    .age_addr_i (age_addr),
    .age_data_i (age_data),
    .age_vld_i  (age_vld),
    .hit_o      (fwd_hit),
    .data_o     (fwd_data)
  );

  // fence stays pending until the queue is empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fence_pend_q <= 1'b0;
    else         fence_pend_q <= (fence_pend_q || fence_i) && (occ_nxt != '0);
  end

  assign ld_ready_o    = !fence_pend_q;
  assign ld_hit_o      = ld_valid_i && fwd_hit;
  assign ld_data_o     = fwd_hit ? fwd_data : mem_rd_data_i;
  assign mem_rd_addr_o = ld_addr_i;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_valid_i,
  input logic              full_o,
  input logic              fence_i,
  input logic              ld_ready_o,
  input logic              mem_wr_req_o,
  input logic [ADDR_W-1:0] mem_wr_addr_o,
  input logic [DATA_W-1:0] mem_wr_data_o,
  input logic              mem_gnt_i,
  input logic [CNT_W-1:0]  occ
);
  a_r5_occ_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CNT_W'(DEPTH));

  a_r5_full_refuses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && st_valid_i && !(mem_wr_req_o && mem_gnt_i) |=> $stable(occ));

  a_r6_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_req_o && !mem_gnt_i |=>
      mem_wr_req_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o));

  a_r2_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_valid_i && !(mem_wr_req_o && mem_gnt_i) |=> $stable(occ));

  a_r8_fence_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_i |=> (occ == '0) || !ld_ready_o);

  a_r8_block_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ready_o |-> occ != '0);
endmodule

bind store_buffer sb_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) i_sb_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .st_valid_i    (st_valid_i),
  .full_o        (full_o),
  .fence_i       (fence_i),
  .ld_ready_o    (ld_ready_o),
  .mem_wr_req_o  (mem_wr_req_o),
  .mem_wr_addr_o (mem_wr_addr_o),
  .mem_wr_data_o (mem_wr_data_o),
  .mem_gnt_i     (mem_gnt_i),
  .occ           (occ)
);

// File: tb/test_store_buffer.sv
`timescale 1ns/1ps
module test_store_buffer;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          st_valid [2];
  logic [AW-1:0] st_addr  [2];
  logic [DW-1:0] st_data  [2];
  logic          full     [2];
  logic          ld_valid [2];
  logic [AW-1:0] ld_addr  [2];
  logic          ld_ready [2];
  logic          ld_hit   [2];
  logic [DW-1:0] ld_data  [2];
  logic          fence    [2];
  logic          wr_req   [2];
  logic [AW-1:0] wr_addr  [2];
  logic [DW-1:0] wr_data  [2];
  logic          gnt      [2];
  logic [AW-1:0] rd_addr  [2];
  logic [DW-1:0] rd_data  [2];

  logic [DW-1:0] mem [256];
  logic          hold;
  int            log_n;
  int            log_core [16];
  logic [AW-1:0] log_addr [16];
  logic [DW-1:0] log_data [16];
  int            n_chk = 0;
  int            n_fail = 0;

  // shared memory: fixed priority, core 0 first, one write per cycle
  assign gnt[0]     = wr_req[0] && !hold;
  assign gnt[1]     = wr_req[1] && !wr_req[0] && !hold;
  assign rd_data[0] = mem[rd_addr[0]];
  assign rd_data[1] = mem[rd_addr[1]];

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (gnt[c]) begin
        mem[wr_addr[c]] <= wr_data[c];
        if (log_n < 16) begin
          log_core[log_n] <= c;
          log_addr[log_n] <= wr_addr[c];
          log_data[log_n] <= wr_data[c];
        end
      end
    end
    if (gnt[0] || gnt[1]) log_n <= log_n + 1;
  end

  store_buffer i_store_buffer (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid[0]), .st_addr_i(st_addr[0]), .st_data_i(st_data[0]),
    .full_o(full[0]), .ld_valid_i(ld_valid[0]), .ld_addr_i(ld_addr[0]),
    .ld_ready_o(ld_ready[0]), .ld_hit_o(ld_hit[0]), .ld_data_o(ld_data[0]),
    .fence_i(fence[0]), .mem_wr_req_o(wr_req[0]), .mem_wr_addr_o(wr_addr[0]),
    .mem_wr_data_o(wr_data[0]), .mem_gnt_i(gnt[0]),
    .mem_rd_addr_o(rd_addr[0]), .mem_rd_data_i(rd_data[0]));

  store_buffer i_store_buffer_b (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid[1]), .st_addr_i(st_addr[1]), .st_data_i(st_data[1]),
    .full_o(full[1]), .ld_valid_i(ld_valid[1]), .ld_addr_i(ld_addr[1]),
    .ld_ready_o(ld_ready[1]), .ld_hit_o(ld_hit[1]), .ld_data_o(ld_data[1]),
    .fence_i(fence[1]), .mem_wr_req_o(wr_req[1]), .mem_wr_addr_o(wr_addr[1]),
    .mem_wr_data_o(wr_data[1]), .mem_gnt_i(gnt[1]),
    .mem_rd_addr_o(rd_addr[1]), .mem_rd_data_i(rd_data[1]));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_store(input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_valid[c] = 1'b1; st_addr[c] = a; st_data[c] = d;
    @(negedge clk);
    st_valid[c] = 1'b0;
  endtask

  task automatic do_load(input int c, input logic [AW-1:0] a,
                         output logic [DW-1:0] d, output logic h);
    ld_valid[c] = 1'b1; ld_addr[c] = a;
    #0.5;
    d = ld_data[c]; h = ld_hit[c];
    ld_valid[c] = 1'b0;
  endtask

  task automatic drain(input string tag);
    hold = 1'b0;
    for (int i = 0; i < 40 && (wr_req[0] || wr_req[1]); i++) @(negedge clk);
    hold = 1'b1;
    chk({tag, " drained"}, {wr_req[1], wr_req[0]}, 0);
  endtask

  task automatic t_reset;
    for (int c = 0; c < 2; c++) begin
      chk("R1 full_o", full[c], 0);
      chk("R1 mem_wr_req_o", wr_req[c], 0);
      chk("R1 ld_ready_o", ld_ready[c], 1);
    end
  endtask

  task automatic t_forward_bypass;
    logic [DW-1:0] d; logic h;
    mem[8'h20] = 16'h5a5a;
    do_store(0, 8'h10, 16'h1111);
    chk("R2 req after store", wr_req[0], 1);
    chk("R2 head addr", wr_addr[0], 8'h10);
    chk("R2 head data", wr_data[0], 16'h1111);
    do_load(0, 8'h10, d, h);
    chk("R3 fwd data", d, 16'h1111);
    chk("R3 fwd hit", h, 1);
    chk("R3 mem not yet written", mem[8'h10], 0);
    do_load(0, 8'h20, d, h);
    chk("R7 bypass data", d, 16'h5a5a);
    chk("R7 bypass hit", h, 0);
  endtask

  task automatic t_youngest;
    logic [DW-1:0] d; logic h;
    do_store(0, 8'h10, 16'h2222);
    do_store(0, 8'h30, 16'h3333);
    do_load(0, 8'h10, d, h);
    chk("R4 youngest data", d, 16'h2222);
    chk("R4 youngest hit", h, 1);
  endtask

  task automatic t_full_and_order;
    logic [DW-1:0] d; logic h;
    chk("R5 not full at 3", full[0], 0);
    do_store(0, 8'h40, 16'h4444);
    chk("R5 full at 4", full[0], 1);
    do_store(0, 8'h50, 16'hdead);
    chk("R5 still full", full[0], 1);
    do_load(0, 8'h50, d, h);
    chk("R5 refused not forwarded", h, 0);
    log_n = 0;
    drain("R6");
    chk("R6 write count", log_n, 4);
    chk("R6 w0", {log_addr[0], log_data[0]}, {8'h10, 16'h1111});
    chk("R6 w1", {log_addr[1], log_data[1]}, {8'h10, 16'h2222});
    chk("R6 w2", {log_addr[2], log_data[2]}, {8'h30, 16'h3333});
    chk("R6 w3", {log_addr[3], log_data[3]}, {8'h40, 16'h4444});
    chk("R5 refused store absent", mem[8'h50], 0);
    chk("R6 final value", mem[8'h10], 16'h2222);
    chk("R5 full cleared", full[0], 0);
  endtask

  task automatic t_hold;
    do_store(1, 8'h60, 16'h0606);
    repeat (3) @(negedge clk);
    chk("R6 held req", wr_req[1], 1);
    chk("R6 held head", {wr_addr[1], wr_data[1]}, {8'h60, 16'h0606});
    chk("R6 not written", mem[8'h60], 0);
    log_n = 0;
    drain("R6");
    chk("R6 single write", log_n, 1);
    chk("R6 written", mem[8'h60], 16'h0606);
  endtask

  task automatic t_fence;
    do_store(0, 8'h70, 16'h0007);
    fence[0] = 1'b1;
    @(negedge clk);
    fence[0] = 1'b0;
    chk("R8 blocked", ld_ready[0], 0);
    repeat (2) @(negedge clk);
    chk("R8 still blocked", ld_ready[0], 0);
    drain("R8");
    chk("R8 released", ld_ready[0], 1);
    fence[0] = 1'b1;
    @(negedge clk);
    fence[0] = 1'b0;
    chk("R8 empty fence no block", ld_ready[0], 1);
  endtask

  task automatic t_litmus;
    logic [DW-1:0] d; logic h;
    st_valid[0] = 1'b1; st_addr[0] = 8'h80; st_data[0] = 16'h1;
    st_valid[1] = 1'b1; st_addr[1] = 8'h81; st_data[1] = 16'h1;
    @(negedge clk);
    st_valid[0] = 1'b0; st_valid[1] = 1'b0;
    do_load(0, 8'h80, d, h); chk("R9 core0 own flag", d, 1);
    do_load(0, 8'h81, d, h); chk("R9 core0 other flag", d, 0);
    do_load(1, 8'h81, d, h); chk("R9 core1 own flag", d, 1);
    do_load(1, 8'h80, d, h); chk("R9 core1 other flag", d, 0);
    log_n = 0;
    drain("R9");
    chk("R9 first writer core0", log_core[0], 0);
    chk("R9 second writer core1", log_core[1], 1);
    chk("R9 flags in memory", {mem[8'h80], mem[8'h81]}, {16'h1, 16'h1});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    log_n = 0;
    hold = 1'b1;
    for (int c = 0; c < 2; c++) begin
      st_valid[c] = 1'b0; st_addr[c] = '0; st_data[c] = '0;
      ld_valid[c] = 1'b0; ld_addr[c] = '0; fence[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward_bypass();
    t_youngest();
    t_full_and_order();
    t_hold();
    t_fence();
    t_litmus();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule